// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block sequences the reference set-point codes of four output rails during power-up and power-down. Each rail has its own state machine. When asked to start, a rail waits a programmable number of cycles and then ramps its code upward by one LSB at a programmable pace until it reaches its target. When asked to stop, it waits a separate delay and then ramps down to zero at its own pace. Different delays give a start and stop order across the rails. The codes drive the reference DACs of the regulators, which are not part of this block.

Rails can share a group number. All rails in a group then start and stop on one group enable, and a fault on any one of them shuts down the whole group. For each rail, a fault either ramps the code down at one LSB per cycle with no delay, or drops it to zero at once. After a fault the rail stays off until its run request is withdrawn. A ramp flag marks rails whose code is moving. A power-good-eligible flag marks rails that have reached their target and are holding it.

Top module: `rail_sequencer`

## Requirements
- R1: After a synchronous active-low reset, every `ref_code` lane is 0 and every `ramping` and `pg_ok` bit is low. A rail that is off always outputs code 0.
- R2: The run request is sampled at a clock edge. The code then stays at 0 for `up_dly`+1 further cycles. After that `ramping` rises, with the code still 0.
- R3: During ramp-up the code rises by exactly 1 every `up_rate`+1 cycles. It stops at the target latched when the ramp began.
- R4: `pg_ok` is high only while a rail holds its latched target, and this starts on the same cycle the code reaches it. `ramping` is high only while the code is moving toward the target or toward zero.
- R5: When the run request drops on a rail that is on, the code holds for `dn_dly`+1 cycles with `pg_ok` low. It then falls by exactly 1 every `dn_rate`+1 cycles, and the rail turns off in the cycle the code reaches 0.
- R6: A rail whose 2-bit group field is 0 runs on `seq_en & rail_en[i]`. A rail with group field g≠0 runs on `seq_en & grp_en[g-1]`, and its `rail_en` bit has no effect.
- R7: A `fault_req` on any rail with a nonzero group acts on every rail that shares that group.
- R8: A fault on an active rail skips the stop delay. With `fault_ramp[i]`=1 the code stays one cycle and then falls by 1 every cycle. With `fault_ramp[i]`=0 the code is 0 on the next cycle.
- R9: After a fault the rail stays off while its run request stays high. It restarts only after the request has been low for at least one cycle while the rail is off.
- R10: The target is latched when ramp-up begins, so later changes to `target` do not move a rail that is on. A target below `MIN_CODE` (the lowest allowed set point) is raised to `MIN_CODE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seq_en | input | 1 | Global enable for all rails |
| rail_en | input | NUM_RAILS | Per-rail enable, used when the rail's group field is 0 |
| rail_grp | input | NUM_RAILS*GRP_W | Group field per rail, rail i at [i*GRP_W +: GRP_W] |
| grp_en | input | 2**GRP_W-1 | Enable of group g at bit g-1 |
| fault_req | input | NUM_RAILS | Per-rail fault request |
| fault_ramp | input | NUM_RAILS | 1: fault ramps down; 0: fault drops code to zero |
| up_dly | input | NUM_RAILS*DLY_W | Start delay per rail |
| dn_dly | input | NUM_RAILS*DLY_W | Stop delay per rail |
| up_rate | input | NUM_RAILS*RATE_W | Ramp-up step period minus one |
| dn_rate | input | NUM_RAILS*RATE_W | Ramp-down step period minus one |
| target | input | NUM_RAILS*CODE_W | Target code per rail |
| ref_code | output | NUM_RAILS*CODE_W | Reference code per rail |
| ramping | output | NUM_RAILS | Code is moving |
| pg_ok | output | NUM_RAILS | Rail is holding its target |

## Verification
Several checks run on every cycle. A code moves by at most one LSB per cycle in either direction, except for a fault drop to zero. An off rail reads zero, ramp-up never reaches or passes the latched target while still ramping, and power-good implies the code equals that target. Two more hold on every cycle: a latched fault keeps a rail off, and rails in the same group always see the same run request. The exact delays, step spacing, group fan-out of a fault, the two fault modes, the restart after withdrawal and the target clamp show only in the bench's timed scenarios. Those scenarios compare each rail's code and flags against cycle counts worked out from the requirements.

// File: rtl/seq_pkg.sv
// Shared types for the rail sequencer.
// Assumes: one state machine per rail, all in one clock domain.
package seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_DLY_UP  = 3'd1,
        ST_RAMP_UP = 3'd2,
        ST_ON      = 3'd3,
        ST_DLY_DN  = 3'd4,
        ST_RAMP_DN = 3'd5
    } rail_st_e;

endpackage

// File: rtl/seq_run_decode.sv
// Turns global, per-rail and per-group enables into one run request per rail.
// It also spreads each fault request over the rail's group.
// Assumes: group 0 means "no group"; group g>0 is enabled by grp_en[g-1].
module seq_run_decode #(
    parameter int NUM_RAILS = 4,
    parameter int GRP_W     = 2
) (
    input  logic                         seq_en,
    input  logic [NUM_RAILS-1:0]         rail_en,
    input  logic [NUM_RAILS*GRP_W-1:0]   rail_grp,
    input  logic [(1<<GRP_W)-2:0]        grp_en,
    input  logic [NUM_RAILS-1:0]         fault_req,
    output logic [NUM_RAILS-1:0]         run_req,
    output logic [NUM_RAILS-1:0]         flt_hit
);
    localparam int NUM_GRP = 1 << GRP_W;

    logic [NUM_GRP-1:0] grp_on;
    logic [NUM_GRP-1:0] grp_flt;

    assign grp_on = {grp_en, 1'b0};

    // Collect fault requests per nonzero group
    always_comb begin
        grp_flt = '0;
        for (int j = 0; j < NUM_RAILS; j++) begin
            if (rail_grp[j*GRP_W +: GRP_W] != '0)
                grp_flt[rail_grp[j*GRP_W +: GRP_W]] = 1'b1 & (grp_flt[rail_grp[j*GRP_W +: GRP_W]] | fault_req[j]);
        end
    end

    // Per-rail run request and effective fault
    always_comb begin
        for (int i = 0; i < NUM_RAILS; i++) begin
            if (rail_grp[i*GRP_W +: GRP_W] == '0)
                run_req[i] = seq_en & rail_en[i];
            else
                run_req[i] = seq_en & grp_on[rail_grp[i*GRP_W +: GRP_W]];
            flt_hit[i] = fault_req[i] | grp_flt[rail_grp[i*GRP_W +: GRP_W]];
        end
    end

endmodule

// File: rtl/seq_rail_fsm.sv
// One rail's power sequencer: start delay, ramp-up, hold, stop delay, ramp-down.
// It also handles the fault shutdown (fast ramp or immediate drop) and the fault latch.
// Assumes: run_req and flt_hit are synchronous; target is sampled only at ramp-up entry.
module seq_rail_fsm
    import seq_pkg::*;
#(
    parameter int CODE_W   = 8,
    parameter int DLY_W    = 8,
    parameter int RATE_W   = 4,
    parameter int MIN_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              flt_hit,
    input  logic              fault_ramp,
    input  logic [DLY_W-1:0]  up_dly,
    input  logic [DLY_W-1:0]  dn_dly,
    input  logic [RATE_W-1:0] up_rate,
    input  logic [RATE_W-1:0] dn_rate,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] ref_code,
    output logic              ramping,
    output logic              pg_ok
);
    localparam logic [CODE_W-1:0] MIN_C = CODE_W'(MIN_CODE);
    localparam logic [CODE_W-1:0] ONE_C = CODE_W'(1);

    rail_st_e          st;
    logic [CODE_W-1:0] code;
    logic [CODE_W-1:0] tgt_q;
    logic [DLY_W-1:0]  dly_cnt;
    logic [RATE_W-1:0] step_cnt;
    logic              fast;
    logic              flt_lat;

    logic [CODE_W-1:0] tgt_eff;
    logic [CODE_W-1:0] code_inc;
    logic [CODE_W-1:0] code_dec;
    logic [RATE_W-1:0] rate_sel;
    logic              step_due;
    logic              flt_take;

    // Clamp target to the minimum set point
    assign tgt_eff  = (target < MIN_C) ? MIN_C : target;
    // Neighbouring codes for stepping
    assign code_inc = code + ONE_C;
    assign code_dec = code - ONE_C;
    // Step pacing for the current ramp direction
    assign rate_sel = (st == ST_RAMP_UP) ? up_rate : dn_rate;
    assign step_due = fast | (step_cnt == rate_sel);
    // A fault acts on any active rail not already in a fast ramp-down
    assign flt_take = flt_hit && (st != ST_OFF) && !((st == ST_RAMP_DN) && fast);

    // Rail state, code and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OFF;
            code     <= '0;
            tgt_q    <= '0;
            dly_cnt  <= '0;
            step_cnt <= '0;
            fast     <= 1'b0;
            flt_lat  <= 1'b0;
        end else if (flt_take) begin
            flt_lat  <= 1'b1;
            step_cnt <= '0;
            if ((st == ST_DLY_UP) || !fault_ramp || (code == '0)) begin
                st   <= ST_OFF;
                code <= '0;
                fast <= 1'b0;
            end else begin
                st   <= ST_RAMP_DN;
                fast <= 1'b1;
            end
        end else begin
            case (st)
                ST_OFF: begin
                    fast <= 1'b0;
                    if (flt_hit)
                        flt_lat <= 1'b1;
                    else if (!run_req)
                        flt_lat <= 1'b0;
                    else if (!flt_lat) begin
                        st      <= ST_DLY_UP;
                        dly_cnt <= '0;
                    end
                end
                ST_DLY_UP: begin
                    if (!run_req)
                        st <= ST_OFF;
                    else if (dly_cnt == up_dly) begin
                        st       <= ST_RAMP_UP;
                        step_cnt <= '0;
                        tgt_q    <= tgt_eff;
                    end else
                        dly_cnt <= dly_cnt + 1'b1;
                end
                ST_RAMP_UP: begin
                    if (!run_req) begin
                        st       <= ST_RAMP_DN;
                        step_cnt <= '0;
                        fast     <= 1'b0;
                    end else if (step_due) begin
                        step_cnt <= '0;
                        code     <= code_inc;
                        if (code_inc == tgt_q)
                            st <= ST_ON;
                    end else
                        step_cnt <= step_cnt + 1'b1;
                end
                ST_ON: begin
                    if (!run_req) begin
                        st      <= ST_DLY_DN;
                        dly_cnt <= '0;
                    end
                end
                ST_DLY_DN: begin
                    if (dly_cnt == dn_dly) begin
                        st       <= ST_RAMP_DN;
                        step_cnt <= '0;
                    end else
                        dly_cnt <= dly_cnt + 1'b1;
                end
                ST_RAMP_DN: begin
                    if (code == '0) begin
                        st   <= ST_OFF;
                        fast <= 1'b0;
                    end else if (step_due) begin
                        step_cnt <= '0;
                        code     <= code_dec;
                        if (code_dec == '0) begin
                            st   <= ST_OFF;
                            fast <= 1'b0;
                        end
                    end else
                        step_cnt <= step_cnt + 1'b1;
                end
                default: begin
                    st   <= ST_OFF;
                    code <= '0;
                end
            endcase
        end
    end

    // Registered outputs straight from state
    assign ref_code = code;
    assign ramping  = (st == ST_RAMP_UP) || (st == ST_RAMP_DN);
    assign pg_ok    = (st == ST_ON);

    // R1
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (ref_code == '0));

    // R3
    up_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RAMP_UP) |-> (ref_code < tgt_q));

    // R3
    rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_code > $past(ref_code)) |-> (ref_code == $past(ref_code) + ONE_C));

    // R5
    fall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_code < $past(ref_code)) && (ref_code != '0)) |-> (ref_code == $past(ref_code) - ONE_C));

    // R4
    pg_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_ok |-> (ref_code == tgt_q));

    // R9
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_lat && (st == ST_OFF)) |=> (st == ST_OFF));

endmodule

// File: rtl/rail_sequencer.sv
// Top of the multi-rail sequencer: run/fault decode plus one state machine per rail.
// Assumes: all inputs synchronous to clk; per-rail fields packed with rail i at slice i.
module rail_sequencer #(
    parameter int NUM_RAILS = 4,
    parameter int CODE_W    = 8,
    parameter int DLY_W     = 8,
    parameter int RATE_W    = 4,
    parameter int GRP_W     = 2,
    parameter int MIN_CODE  = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          seq_en,
    input  logic [NUM_RAILS-1:0]          rail_en,
    input  logic [NUM_RAILS*GRP_W-1:0]    rail_grp,
    input  logic [(1<<GRP_W)-2:0]         grp_en,
    input  logic [NUM_RAILS-1:0]          fault_req,
    input  logic [NUM_RAILS-1:0]          fault_ramp,
    input  logic [NUM_RAILS*DLY_W-1:0]    up_dly,
    input  logic [NUM_RAILS*DLY_W-1:0]    dn_dly,
    input  logic [NUM_RAILS*RATE_W-1:0]   up_rate,
    input  logic [NUM_RAILS*RATE_W-1:0]   dn_rate,
    input  logic [NUM_RAILS*CODE_W-1:0]   target,
    output logic [NUM_RAILS*CODE_W-1:0]   ref_code,
    output logic [NUM_RAILS-1:0]          ramping,
    output logic [NUM_RAILS-1:0]          pg_ok
);
    logic [NUM_RAILS-1:0] run_req;
    logic [NUM_RAILS-1:0] flt_hit;

    seq_run_decode #(
        .NUM_RAILS (NUM_RAILS),
        .GRP_W     (GRP_W)
    ) u_decode (
        .seq_en    (seq_en),
        .rail_en   (rail_en),
        .rail_grp  (rail_grp),
        .grp_en    (grp_en),
        .fault_req (fault_req),
        .run_req   (run_req),
        .flt_hit   (flt_hit)
    );

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        seq_rail_fsm #(
            .CODE_W   (CODE_W),
            .DLY_W    (DLY_W),
            .RATE_W   (RATE_W),
            .MIN_CODE (MIN_CODE)
        ) u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .run_req    (run_req[i]),
            .flt_hit    (flt_hit[i]),
            .fault_ramp (fault_ramp[i]),
            .up_dly     (up_dly[i*DLY_W +: DLY_W]),
            .dn_dly     (dn_dly[i*DLY_W +: DLY_W]),
            .up_rate    (up_rate[i*RATE_W +: RATE_W]),
            .dn_rate    (dn_rate[i*RATE_W +: RATE_W]),
            .target     (target[i*CODE_W +: CODE_W]),
            .ref_code   (ref_code[i*CODE_W +: CODE_W]),
            .ramping    (ramping[i]),
            .pg_ok      (pg_ok[i])
        );

        for (genvar j = i + 1; j < NUM_RAILS; j++) begin : g_pair
            // R6
            grp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((rail_grp[i*GRP_W +: GRP_W] == rail_grp[j*GRP_W +: GRP_W]) &&
                 (rail_grp[i*GRP_W +: GRP_W] != '0)) |-> (run_req[i] == run_req[j]));
            // R7
            grp_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ((rail_grp[i*GRP_W +: GRP_W] == rail_grp[j*GRP_W +: GRP_W]) &&
                 (rail_grp[i*GRP_W +: GRP_W] != '0)) |-> (flt_hit[i] == flt_hit[j]));
        end
    end

endmodule

// File: tb/rail_sequencer_bench.sv
// Scoreboard bench: scenario tasks queue timed expectations, a negedge monitor compares them.
module rail_sequencer_bench;
    localparam int NR = 4;
    localparam int MIN_C = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            seq_en = 1'b0;
    logic [NR-1:0]   rail_en = '0;
    logic [7:0]      rail_grp = 8'b00_01_01_00;
    logic [2:0]      grp_en = '0;
    logic [NR-1:0]   fault_req = '0;
    logic [NR-1:0]   fault_ramp = 4'b0011;
    logic [31:0]     up_dly = {8'd0, 8'd1, 8'd0, 8'd2};
    logic [31:0]     dn_dly = {8'd0, 8'd0, 8'd10, 8'd3};
    logic [15:0]     up_rate = {4'd0, 4'd0, 4'd0, 4'd1};
    logic [15:0]     dn_rate = '0;
    logic [31:0]     target = {8'd2, 8'd7, 8'd6, 8'd8};
    logic [31:0]     ref_code;
    logic [NR-1:0]   ramping;
    logic [NR-1:0]   pg_ok;

    rail_sequencer u_rail_sequencer (
        .clk(clk), .rst_n(rst_n), .seq_en(seq_en), .rail_en(rail_en),
        .rail_grp(rail_grp), .grp_en(grp_en), .fault_req(fault_req),
        .fault_ramp(fault_ramp), .up_dly(up_dly), .dn_dly(dn_dly),
        .up_rate(up_rate), .dn_rate(dn_rate), .target(target),
        .ref_code(ref_code), .ramping(ramping), .pg_ok(pg_ok)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    cyc;
        int    rail;
        int    code;
        bit    rmp;
        bit    pg;
        string tag;
    } exp_t;

    exp_t  sb[$];
    exp_t  cur;
    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every expectation due at this cycle and compare
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            cur = sb.pop_front();
            total++;
            if (cur.cyc < cyc) begin
                bad++;
                $display("FAIL %s missed check at cycle %0d (now %0d) actual=none expected=sampled",
                         cur.tag, cur.cyc, cyc);
            end else if (int'(ref_code[cur.rail*8 +: 8]) != cur.code ||
                         ramping[cur.rail] != cur.rmp || pg_ok[cur.rail] != cur.pg) begin
                bad++;
                $display("FAIL %s rail%0d cyc%0d actual code=%0d ramp=%0b pg=%0b expected code=%0d ramp=%0b pg=%0b",
                         cur.tag, cur.rail, cyc, ref_code[cur.rail*8 +: 8], ramping[cur.rail],
                         pg_ok[cur.rail], cur.code, cur.rmp, cur.pg);
            end
        end
    end

    task automatic expect_at(int c, int r, int code, bit rmp, bit pg, string tag);
        exp_t e;
        e.cyc = c; e.rail = r; e.code = code; e.rmp = rmp; e.pg = pg; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : driver
        int n;
        tick(3);
        rst_n = 1'b1;
        n = cyc;
        // R1: reset state on all rails
        for (int r = 0; r < NR; r++) expect_at(n + 1, r, 0, 1'b0, 1'b0, "R1");
        tick(3);

        // Rail 0 start: delay 2, step every 2 cycles, target 8; grouped rail 1 ignores rail_en (R6)
        seq_en = 1'b1;
        rail_en = 4'b0111;
        n = cyc;
        expect_at(n + 1,  0, 0, 1'b0, 1'b0, "R2");
        expect_at(n + 3,  0, 0, 1'b0, 1'b0, "R2");
        expect_at(n + 4,  0, 0, 1'b1, 1'b0, "R2");
        expect_at(n + 5,  1, 0, 1'b0, 1'b0, "R6");
        expect_at(n + 6,  0, 1, 1'b1, 1'b0, "R3");
        expect_at(n + 12, 0, 4, 1'b1, 1'b0, "R3");
        expect_at(n + 19, 0, 7, 1'b1, 1'b0, "R4");
        expect_at(n + 20, 0, 8, 1'b0, 1'b1, "R4");
        expect_at(n + 20, 1, 0, 1'b0, 1'b0, "R6");
        tick(25);

        // R10: a new target while on has no effect
        target[7:0] = 8'd20;
        n = cyc;
        expect_at(n + 3,  0, 8, 1'b0, 1'b1, "R10");
        expect_at(n + 10, 0, 8, 1'b0, 1'b1, "R10");
        tick(12);

        // R5: rail 0 stop, delay 3, step every cycle
        rail_en[0] = 1'b0;
        n = cyc;
        expect_at(n + 4,  0, 8, 1'b0, 1'b0, "R5");
        expect_at(n + 5,  0, 8, 1'b1, 1'b0, "R5");
        expect_at(n + 6,  0, 7, 1'b1, 1'b0, "R5");
        expect_at(n + 12, 0, 1, 1'b1, 1'b0, "R5");
        expect_at(n + 13, 0, 0, 1'b0, 1'b0, "R5");
        tick(16);

        // R6: group 1 enable starts rails 1 and 2 together
        grp_en = 3'b001;
        n = cyc;
        expect_at(n + 2,  1, 0, 1'b1, 1'b0, "R6");
        expect_at(n + 5,  1, 3, 1'b1, 1'b0, "R6");
        expect_at(n + 8,  1, 6, 1'b0, 1'b1, "R6");
        expect_at(n + 9,  2, 6, 1'b1, 1'b0, "R6");
        expect_at(n + 10, 2, 7, 1'b0, 1'b1, "R6");
        tick(14);

        // R7/R8: one-cycle fault on rail 1 reaches rail 2 (hard drop); rail 1 fast ramp
        fault_req[1] = 1'b1;
        n = cyc;
        expect_at(n + 1, 1, 6, 1'b1, 1'b0, "R8");
        expect_at(n + 1, 2, 0, 1'b0, 1'b0, "R7");
        expect_at(n + 2, 1, 5, 1'b1, 1'b0, "R8");
        expect_at(n + 7, 1, 0, 1'b0, 1'b0, "R8");
        tick(1);
        fault_req[1] = 1'b0;
        tick(19);

        // R9: latched fault holds rails off while group enable stays high
        n = cyc;
        expect_at(n + 3, 1, 0, 1'b0, 1'b0, "R9");
        expect_at(n + 3, 2, 0, 1'b0, 1'b0, "R9");
        tick(4);
        grp_en = 3'b000;
        tick(2);
        grp_en = 3'b001;
        n = cyc;
        expect_at(n + 8, 1, 6, 1'b0, 1'b1, "R9");
        tick(12);

        // R6/R5: global disable takes rails down by their own stop timing
        seq_en = 1'b0;
        n = cyc;
        expect_at(n + 2,  2, 7, 1'b1, 1'b0, "R6");
        expect_at(n + 11, 1, 6, 1'b0, 1'b0, "R6");
        expect_at(n + 12, 1, 6, 1'b1, 1'b0, "R5");
        expect_at(n + 13, 1, 5, 1'b1, 1'b0, "R5");
        tick(22);

        // R10: target 2 below the minimum is raised to MIN_C
        seq_en = 1'b1;
        rail_en[3] = 1'b1;
        n = cyc;
        expect_at(n + 7, 3, MIN_C - 1, 1'b1, 1'b0, "R10");
        expect_at(n + 8, 3, MIN_C, 1'b0, 1'b1, "R10");
        tick(12);

        while (sb.size() > 0) tick(1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule